// File: doc/BRIEF.md
# Processor On-Chip I/O Port

This block is the small bidirectional port that lives inside the processor and answers at the two lowest addresses of its memory space. Address 0 holds a direction register and address 1 holds an output latch. Each pin whose direction bit is set drives the matching latch bit. Each pin whose direction bit is clear is released.

The port merges the pin inputs with the direction setting for reads of address 1. It also exports the level seen on each port line. The three lowest lines select the memory banking: the low-ROM enable, the high-ROM enable and the character/IO select.

Every processor write is still passed on to the memory behind the port, including writes to the port's own two addresses. Reads from any other address return the external data bus unchanged.

Top module: `cpu_io_port`

## Requirements
- R1: After reset, the direction register and the output latch both hold 0xFF, so `pin_oe` and `pin_out` both read 0xFF.
- R2: A write to address 0x0000 loads the direction register, which appears on `pin_oe` after the clock edge. A read of address 0x0000 returns that register on `rdata`.
- R3: A write to address 0x0001 loads the output latch after the clock edge.
- R4: A read of address 0x0001 returns `pin_in | ~direction`. Every bit whose direction bit is 0 reads as 1.
- R5: `mem_we` follows `we` for every address, including 0x0000 and 0x0001.
- R6: A read of any address other than 0x0000 and 0x0001 returns `ext_rdata` unchanged. A write to such an address leaves the direction register and the output latch unchanged.
- R7: `pin_out` equals latch AND direction. A pin whose direction bit is 0 has `pin_oe` low and drives 0.
- R8: The line level is the latch bit for an output bit and the `pin_in` bit for an input bit. `bank_lo` is the level of bit 0, `bank_hi` of bit 1 and `bank_char` of bit 2.
- R9: Address decoding uses all 16 address bits, so addresses such as 0x0100 or 0x8001 are not the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data |
| we | input | 1 | Processor write strobe |
| ext_rdata | input | 8 | Read data from the external bus |
| rdata | output | 8 | Read data presented to the processor |
| mem_we | output | 1 | Write strobe forwarded to external memory |
| pin_in | input | 8 | Levels sensed on the port pins |
| pin_out | output | 8 | Values driven on the port pins |
| pin_oe | output | 8 | Per-pin output enable |
| bank_lo | output | 1 | Low-ROM banking control (line 0) |
| bank_hi | output | 1 | High-ROM banking control (line 1) |
| bank_char | output | 1 | Character/IO banking control (line 2) |

## Verification
The bench sweeps all 256 direction values. For each one it loads a latch value unrelated to the direction, so a swapped AND or a lost mask shows up in `pin_out`. Reads of address 1 are then tried with pins all low, all high and a mixed pattern. These three cases separate the forced-high input bits from the sensed output bits, and they show whether the bank controls take the latch or the pin. Writes and reads at unrelated addresses, including ones that alias in the low bits, confirm that the port state holds, the bus passes through and the write strobe is forwarded.

// File: rtl/cpu_io_port.sv
module cpu_io_port #(
  parameter int AW        = 16,
  parameter int W         = 8,
  parameter logic [AW-1:0] DIR_ADDR  = '0,
  parameter logic [AW-1:0] DATA_ADDR = 1,
  parameter logic [W-1:0]  RST_VAL   = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          we,
  input  logic [W-1:0]  ext_rdata,
  output logic [W-1:0]  rdata,
  output logic          mem_we,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          bank_lo,
  output logic          bank_hi,
  output logic          bank_char
);

  logic [W-1:0] dir_q, lat_q, level;
  logic         hit_dir, hit_dat;

  assign hit_dir = (addr == DIR_ADDR);
  assign hit_dat = (addr == DATA_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= RST_VAL;
      lat_q <= RST_VAL;
    end else if (we) begin
      if (hit_dir) dir_q <= wdata;
      if (hit_dat) lat_q <= wdata;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_oe[i]  = dir_q[i];
    assign pin_out[i] = dir_q[i] & lat_q[i];
    assign level[i]   = dir_q[i] ? lat_q[i] : pin_in[i];
  end

  always_comb begin
    if (hit_dir)      rdata = dir_q;
    else if (hit_dat) rdata = pin_in | ~dir_q;
    else              rdata = ext_rdata;
  end

  assign mem_we    = we;
  assign bank_lo   = level[0];
  assign bank_hi   = level[1];
  assign bank_char = level[2];

endmodule

// File: rtl/cpu_io_port_chk.sv
module cpu_io_port_chk #(
  parameter int AW = 16,
  parameter int W  = 8,
  parameter logic [AW-1:0] DIR_ADDR  = '0,
  parameter logic [AW-1:0] DATA_ADDR = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic          we,
  input logic [W-1:0]  ext_rdata,
  input logic [W-1:0]  rdata,
  input logic          mem_we,
  input logic [W-1:0]  pin_in,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe
);

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == DIR_ADDR) |=> (pin_oe == $past(wdata)));

  assert_dir_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == DIR_ADDR) |-> (rdata == pin_oe));

  assert_data_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == DATA_ADDR) |-> (rdata == (pin_in | ~pin_oe)));

  assert_fwd_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we == we);

  assert_pass_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != DIR_ADDR && addr != DATA_ADDR) |-> (rdata == ext_rdata));

  assert_hold_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != DIR_ADDR && addr != DATA_ADDR) |=> ($stable(pin_oe) && $stable(pin_out)));

  assert_released_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

endmodule

bind cpu_io_port cpu_io_port_chk #(.AW(AW), .W(W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
  .ext_rdata(ext_rdata), .rdata(rdata), .mem_we(mem_we), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/cpu_io_port_test.sv
module cpu_io_port_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = 16'h4000;
  logic [7:0]  wdata = 0, ext_rdata = 0, pin_in = 0;
  logic        we = 0;
  logic [7:0]  rdata, pin_out, pin_oe;
  logic        mem_we, bank_lo, bank_hi, bank_char;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_io_port uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .ext_rdata(ext_rdata), .rdata(rdata), .mem_we(mem_we), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .bank_lo(bank_lo), .bank_hi(bank_hi),
    .bank_char(bank_char));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    #1 chk("R5 mem_we", {31'd0, mem_we}, 1);
    @(posedge clk);
    #1 we = 0; addr = 16'h4000;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1 chk(req, {24'd0, rdata}, {24'd0, exp});
    chk("R5 idle", {31'd0, mem_we}, 0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 pin_oe", {24'd0, pin_oe}, 32'hFF);
    chk("R1 pin_out", {24'd0, pin_out}, 32'hFF);
    rd(16'h0000, 8'hFF, "R1 dir read");

    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv, lv;
      dv = d[7:0];
      lv = dv ^ 8'h5A ^ {dv[3:0], dv[7:4]};
      wr(16'h0000, dv);
      chk("R2 pin_oe", {24'd0, pin_oe}, {24'd0, dv});
      rd(16'h0000, dv, "R2 dir read");
      wr(16'h0001, lv);
      chk("R3 R7 pin_out", {24'd0, pin_out}, {24'd0, lv & dv});
      for (int k = 0; k < 3; k++) begin
        logic [7:0] p, lvl;
        p = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (dv ^ 8'hA5);
        pin_in = p;
        rd(16'h0001, p | ~dv, "R4 data read");
        lvl = (lv & dv) | (p & ~dv);
        chk("R8 bank", {29'd0, bank_char, bank_hi, bank_lo}, {29'd0, lvl[2:0]});
      end
      wr(16'h1234 ^ {8'd0, dv}, ~dv);
      wr(16'h0100, 8'h00);
      wr(16'h8001, ~lv);
      chk("R6 R9 dir hold", {24'd0, pin_oe}, {24'd0, dv});
      chk("R6 R9 latch hold", {24'd0, pin_out}, {24'd0, lv & dv});
      ext_rdata = dv ^ 8'h3C;
      rd(16'h2000 | {8'd0, dv}, dv ^ 8'h3C, "R6 pass");
      rd(16'h0100, dv ^ 8'h3C, "R9 alias pass");
    end

    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    #1 rst_n = 1;
    chk("R1 re-reset oe", {24'd0, pin_oe}, 32'hFF);
    chk("R1 re-reset out", {24'd0, pin_out}, 32'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule